// File: doc/BRIEF.md
# Closed-Loop Flash Bulk Erase Controller

This block sits on the host side of a byte-wide flash array and erases the whole array on request. After a start strobe it first drives every byte to 00H through a separate byte-programming sequencer. It reaches that sequencer over a request port, one address at a time, in ascending order. Only when every byte reports a good program result does it begin erasing. It then alternates timed bulk-erase pulses with verify sweeps over the flash command bus.

Each erase pulse is a two-write command (set-up, then confirm) followed by a wait of a fixed number of clock cycles. A verify sweep reads bytes upward. Each read is preceded by a verify command write that carries the same address. The sweep stops at the first byte that does not read FFH. That address is held in a resume register, and the next sweep starts there rather than at zero. The controller raises `done` when the top address reads FFH. It raises `fail` if preprogramming reports an error, or if the pulse budget runs out.

Top module: `flash_bulk_erase_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, `done`, `fail`, `bus_req` and `prog_req` are all low.
- R2: After `start`, the controller requests programming of every address from 0 to the top address, strictly ascending, with `prog_data` = 00H. No bus transfer happens before the last of these requests is acknowledged.
- R3: If `prog_ok` is low with `prog_ack`, the controller raises `fail`. It issues no further programming request and no bus transfer for that run.
- R4: An erase pulse is a bus write of 20H followed by a second write of 20H. The next bus transfer starts no sooner than PULSE_CYCLES clock cycles after the confirm write is acknowledged.
- R5: Every verify read (`bus_we` low) is immediately preceded by a bus write of A0H to the same address. A byte counts as erased only when the read returns exactly FFH.
- R6: The first verify sweep after the erase phase begins starts at address 0. Each sweep reads consecutive ascending addresses and ends at the first byte not reading FFH.
- R7: Every later sweep starts at the address where the previous sweep found a byte not reading FFH.
- R8: When the top address reads FFH in a sweep, `done` goes high and `fail` stays low. Both hold until the next `start`.
- R9: If a sweep fails after MAX_PULSES erase pulses, `fail` goes high. Exactly MAX_PULSES pulses have then been issued.
- R10: A bus request stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until it is acknowledged.
- R11: A `start` while `done` or `fail` is high clears that flag and runs the whole flow again from preprogramming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase run (idle, done or fail state) |
| done | output | 1 | Array verified erased |
| fail | output | 1 | Preprogram error or pulse budget exhausted |
| bus_req | output | 1 | Flash bus transfer request, held until ack |
| bus_we | output | 1 | 1 = command write, 0 = data read |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | 8 | Command byte for writes |
| bus_ack | input | 1 | Transfer complete; read data valid |
| bus_rdata | input | 8 | Read data, valid with bus_ack |
| prog_req | output | 1 | Byte program request, held until ack |
| prog_addr | output | AW | Address to program |
| prog_data | output | 8 | Value to program (00H) |
| prog_ack | input | 1 | Programming sequencer finished |
| prog_ok | input | 1 | Program result, valid with prog_ack |

## Verification
The erase phase is driven with per-byte pulse thresholds. A uniform pattern, where every byte erases after one pulse, gives a single full sweep. A staggered pattern makes slow bytes stall sweeps in the middle of the array, which separates resume-from-stored-address from restart-at-zero. A pattern with only the top byte slow shows that the final address alone stops `done`. A byte that never erases within budget separates the pulse limit from normal completion. Unerased bytes return FEH rather than 00H, which shows the controller compares the whole byte. The bus responder stretches acknowledges by an address-dependent delay to check that requests hold steady. A preprogramming error mid-array, followed by a rerun, checks the abort path and the restart.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PRE_REQ,
    ST_PRE_WAIT,
    ST_ER_SETUP,
    ST_ER_CONFIRM,
    ST_PULSE,
    ST_VFY_CMD,
    ST_VFY_READ,
    ST_DONE,
    ST_FAIL
  } ctl_state_t;
endpackage

// File: rtl/bfe_pulse_timer.sv
module bfe_pulse_timer #(
  parameter int unsigned PULSE_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)
      remain <= '0;
    else if (fire)
      remain <= CW'(PULSE_CYCLES);
    else if (remain != '0)
      remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  assert_fire_when_idle_R4: assert property (@(posedge clk) disable iff (rst)
    fire |-> !busy);
  assert_busy_after_fire_R4: assert property (@(posedge clk) disable iff (rst)
    fire |=> busy);
endmodule

// File: rtl/bfe_pulse_counter.sv
module bfe_pulse_counter #(
  parameter int unsigned MAX_PULSES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int unsigned CW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] issued;

  always_ff @(posedge clk) begin
    if (rst || clr)
      issued <= '0;
    else if (inc)
      issued <= issued + 1'b1;
  end

  assign at_limit = (issued == CW'(MAX_PULSES));

  assert_no_pulse_past_cap_R9: assert property (@(posedge clk) disable iff (rst)
    inc |-> !at_limit);
endmodule

// File: rtl/bfe_addr_track.sv
module bfe_addr_track #(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          mark,
  input  logic          rewind,
  output logic [AW-1:0] cursor,
  output logic          at_last
);
  logic [AW-1:0] resume_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cursor   <= '0;
      resume_q <= '0;
    end else begin
      if (step)
        cursor <= cursor + 1'b1;
      else if (rewind)
        cursor <= resume_q;
      if (mark)
        resume_q <= cursor;
    end
  end

  assign at_last = (cursor == {AW{1'b1}});

  assert_resume_never_drops_R7: assert property (@(posedge clk) disable iff (rst)
    !clr && !$past(rst) |=> resume_q >= $past(resume_q));
  assert_mark_at_or_above_R7: assert property (@(posedge clk) disable iff (rst)
    mark |-> cursor >= resume_q);
  assert_no_step_past_top_R6: assert property (@(posedge clk) disable iff (rst)
    step |-> !at_last);
endmodule

// File: rtl/bfe_bus_port.sv
module bfe_bus_port #(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue,
  input  logic          issue_we,
  input  logic [AW-1:0] issue_addr,
  input  logic [7:0]    issue_data,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          xfer_done,
  output logic [7:0]    rd_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      xfer_done <= 1'b0;
      rd_q      <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (issue) begin
        bus_req   <= 1'b1;
        bus_we    <= issue_we;
        bus_addr  <= issue_addr;
        bus_wdata <= issue_data;
      end else if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        xfer_done <= 1'b1;
        rd_q      <= bus_rdata;
      end
    end
  end

  assert_req_holds_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                            && $stable(bus_wdata));
  assert_no_issue_overlap_R10: assert property (@(posedge clk) disable iff (rst)
    issue |-> !bus_req && !xfer_done);
endmodule

// File: rtl/flash_bulk_erase_ctrl.sv
module flash_bulk_erase_ctrl
  import bfe_pkg::*;
#(
  parameter int unsigned AW           = 17,
  parameter int unsigned PULSE_CYCLES = 500000,
  parameter int unsigned MAX_PULSES   = 1000,
  parameter logic [7:0]  ERASE_CODE   = 8'h20,
  parameter logic [7:0]  VERIFY_CODE  = 8'hA0,
  parameter logic [7:0]  PRE_VALUE    = 8'h00,
  parameter logic [7:0]  ERASED_VALUE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          done,
  output logic          fail,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic          bus_ack,
  input  logic [7:0]    bus_rdata,
  output logic          prog_req,
  output logic [AW-1:0] prog_addr,
  output logic [7:0]    prog_data,
  input  logic          prog_ack,
  input  logic          prog_ok
);
  ctl_state_t    state, state_n;
  logic          inflight;
  logic          issue, iss_we;
  logic [AW-1:0] iss_addr;
  logic [7:0]    iss_data;
  logic          xfer_done;
  logic [7:0]    rd_q;
  logic          tmr_fire, tmr_busy;
  logic          cnt_clr, cnt_inc, cnt_at_limit;
  logic          a_clr, a_step, a_mark, a_rewind;
  logic [AW-1:0] cursor;
  logic          at_last;

  bfe_pulse_timer #(.PULSE_CYCLES(PULSE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .fire(tmr_fire), .busy(tmr_busy));

  bfe_pulse_counter #(.MAX_PULSES(MAX_PULSES)) u_count (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .at_limit(cnt_at_limit));

  bfe_addr_track #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .clr(a_clr), .step(a_step), .mark(a_mark),
    .rewind(a_rewind), .cursor(cursor), .at_last(at_last));

  bfe_bus_port #(.AW(AW)) u_bus (
    .clk(clk), .rst(rst), .issue(issue), .issue_we(iss_we),
    .issue_addr(iss_addr), .issue_data(iss_data),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .rd_q(rd_q));

  always_comb begin
    state_n  = state;
    issue    = 1'b0;
    iss_we   = 1'b1;
    iss_addr = '0;
    iss_data = '0;
    tmr_fire = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    a_clr    = 1'b0;
    a_step   = 1'b0;
    a_mark   = 1'b0;
    a_rewind = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          a_clr   = 1'b1;
          cnt_clr = 1'b1;
          state_n = ST_PRE_REQ;
        end
      end
      ST_PRE_REQ: state_n = ST_PRE_WAIT;
      ST_PRE_WAIT: begin
        if (prog_ack) begin
          if (!prog_ok) begin
            state_n = ST_FAIL;
          end else if (at_last) begin
            a_clr   = 1'b1;
            state_n = ST_ER_SETUP;
          end else begin
            a_step  = 1'b1;
            state_n = ST_PRE_REQ;
          end
        end
      end
      ST_ER_SETUP: begin
        issue    = !inflight;
        iss_data = ERASE_CODE;
        if (xfer_done) state_n = ST_ER_CONFIRM;
      end
      ST_ER_CONFIRM: begin
        issue    = !inflight;
        iss_data = ERASE_CODE;
        if (xfer_done) begin
          tmr_fire = 1'b1;
          cnt_inc  = 1'b1;
          state_n  = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (!tmr_busy) begin
          a_rewind = 1'b1;
          state_n  = ST_VFY_CMD;
        end
      end
      ST_VFY_CMD: begin
        issue    = !inflight;
        iss_addr = cursor;
        iss_data = VERIFY_CODE;
        if (xfer_done) state_n = ST_VFY_READ;
      end
      ST_VFY_READ: begin
        issue    = !inflight;
        iss_we   = 1'b0;
        iss_addr = cursor;
        if (xfer_done) begin
          if (rd_q == ERASED_VALUE) begin
            if (at_last) begin
              state_n = ST_DONE;
            end else begin
              a_step  = 1'b1;
              state_n = ST_VFY_CMD;
            end
          end else if (cnt_at_limit) begin
            state_n = ST_FAIL;
          end else begin
            a_mark  = 1'b1;
            state_n = ST_ER_SETUP;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      inflight <= 1'b0;
      prog_req <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      state <= state_n;
      if (issue)
        inflight <= 1'b1;
      else if (xfer_done)
        inflight <= 1'b0;
      if (state == ST_PRE_REQ)
        prog_req <= 1'b1;
      else if (prog_ack)
        prog_req <= 1'b0;
      done <= (state_n == ST_DONE);
      fail <= (state_n == ST_FAIL);
    end
  end

  assign prog_addr = cursor;
  assign prog_data = PRE_VALUE;

  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && fail));
  assert_ports_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(prog_req && bus_req));
  assert_no_bus_in_preprogram_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE_REQ || state == ST_PRE_WAIT) |-> !bus_req);
  assert_preprogram_abort_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE_WAIT && prog_ack && !prog_ok) |=> fail && !bus_req && !prog_req);
  assert_start_clears_flags_R11: assert property (@(posedge clk) disable iff (rst)
    (start && (done || fail)) |=> !done && !fail);
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !done && !fail && !bus_req && !prog_req);
endmodule

// File: tb/test_flash_bulk_erase_ctrl.sv
module test_flash_bulk_erase_ctrl;
  localparam int AW = 4;
  localparam int DEPTH = 16;
  localparam int PULSE = 20;
  localparam int MAXP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done, fail, bus_req, bus_we, prog_req;
  logic [AW-1:0] bus_addr, prog_addr;
  logic [7:0] bus_wdata, prog_data;
  logic bus_ack = 1'b0;
  logic [7:0] bus_rdata = 8'h00;
  logic prog_ack = 1'b0;
  logic prog_ok = 1'b0;

  always #10 clk = ~clk;

  flash_bulk_erase_ctrl #(.AW(AW), .PULSE_CYCLES(PULSE), .MAX_PULSES(MAXP)) i_flash_bulk_erase_ctrl (
    .clk(clk), .rst(rst), .start(start), .done(done), .fail(fail),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .prog_req(prog_req), .prog_addr(prog_addr),
    .prog_data(prog_data), .prog_ack(prog_ack), .prog_ok(prog_ok));

  int total = 0;
  int bad = 0;
  int cycle = 0;
  int need [0:DEPTH-1];
  int pfail_addr = -1;
  int pulses, xfers, reads, prog_cnt;
  int r2_err, r4_err, r5_err, r10_err;
  bit armed, new_sweep, pend_v, gap_chk;
  int pend_addr, confirm_cyc, hold_left;
  logic [AW-1:0] seen_addr;
  logic [7:0] seen_data;
  logic seen_we;
  int sweep_first [0:15];
  int exp_first [0:15];
  int exp_pulses, exp_reads;
  bit exp_ok;

  always @(posedge clk) cycle <= cycle + 1;

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=0", wd);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // flash bus responder with address-dependent ack delay
  initial begin
    hold_left = -1;
    forever begin
      @(negedge clk);
      bus_ack = 1'b0;
      if (bus_req) begin
        if (hold_left < 0) begin
          seen_addr = bus_addr;
          seen_data = bus_wdata;
          seen_we   = bus_we;
          hold_left = int'(bus_addr) % 3;
        end
        if (seen_addr != bus_addr || seen_data != bus_wdata || seen_we != bus_we) r10_err++;
        if (hold_left > 0) begin
          hold_left--;
        end else begin
          hold_left = -1;
          xfers++;
          if (xfers == 1 && prog_cnt != DEPTH) r2_err++;
          if (bus_we) begin
            if (bus_wdata == 8'h20) begin
              if (!armed) armed = 1'b1;
              else begin
                armed = 1'b0;
                pulses++;
                confirm_cyc = cycle;
                gap_chk = 1'b1;
                new_sweep = 1'b1;
              end
            end else if (bus_wdata == 8'hA0) begin
              if (armed) r4_err++;
              if (gap_chk) begin
                if (cycle - confirm_cyc < PULSE || cycle - confirm_cyc > PULSE + 6) r4_err++;
                gap_chk = 1'b0;
              end
              pend_v = 1'b1;
              pend_addr = int'(bus_addr);
            end else begin
              r5_err++;
            end
          end else begin
            if (!pend_v || pend_addr != int'(bus_addr)) r5_err++;
            pend_v = 1'b0;
            reads++;
            if (new_sweep) begin
              sweep_first[pulses] = int'(bus_addr);
              new_sweep = 1'b0;
            end
            bus_rdata = (pulses >= need[bus_addr]) ? 8'hFF : 8'hFE;
          end
          bus_ack = 1'b1;
        end
      end
    end
  end

  // byte programming sequencer model
  initial begin
    forever begin
      @(negedge clk);
      prog_ack = 1'b0;
      if (prog_req) begin
        if (int'(prog_addr) != prog_cnt || prog_data != 8'h00 || xfers != 0) r2_err++;
        prog_cnt++;
        prog_ok = (int'(prog_addr) != pfail_addr);
        prog_ack = 1'b1;
      end
    end
  end

  task automatic clear_model();
    pulses = 0; xfers = 0; reads = 0; prog_cnt = 0;
    r2_err = 0; r4_err = 0; r5_err = 0; r10_err = 0;
    armed = 0; new_sweep = 0; pend_v = 0; gap_chk = 0;
    for (int i = 0; i < 16; i++) sweep_first[i] = -1;
  endtask

  task automatic predict();
    int cur = 0;
    exp_ok = 1'b0; exp_reads = 0; exp_pulses = 0;
    for (int i = 0; i < 16; i++) exp_first[i] = -1;
    for (int p = 1; p <= MAXP; p++) begin
      exp_pulses = p;
      exp_first[p] = cur;
      while (cur < DEPTH && need[cur] <= p) begin
        exp_reads++;
        cur++;
      end
      if (cur == DEPTH) begin
        exp_ok = 1'b1;
        break;
      end
      exp_reads++;
    end
  endtask

  task automatic run_flow();
    int w = 0;
    clear_model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done && !fail, "R11", "flags cleared by start", int'(done | fail), 0);
    while (!(done || fail) && w < 20000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic check_erase(input string name);
    predict();
    run_flow();
    check(done == exp_ok, "R8", {name, " done"}, int'(done), int'(exp_ok));
    check(fail == !exp_ok, "R9", {name, " fail"}, int'(fail), int'(!exp_ok));
    check(pulses == exp_pulses, "R9", {name, " pulse count"}, pulses, exp_pulses);
    check(reads == exp_reads, "R6", {name, " verify reads"}, reads, exp_reads);
    check(prog_cnt == DEPTH && r2_err == 0, "R2", {name, " preprogram order"}, r2_err, 0);
    check(r4_err == 0, "R4", {name, " pulse command and length"}, r4_err, 0);
    check(r5_err == 0, "R5", {name, " verify command pairing"}, r5_err, 0);
    check(r10_err == 0, "R10", {name, " request stability"}, r10_err, 0);
    check(sweep_first[1] == 0, "R6", {name, " first sweep start"}, sweep_first[1], 0);
    for (int p = 2; p <= exp_pulses; p++)
      check(sweep_first[p] == exp_first[p], "R7", {name, " sweep resume"},
            sweep_first[p], exp_first[p]);
    repeat (5) @(negedge clk);
    check(done == exp_ok && fail == !exp_ok, "R8", {name, " flags held"},
          int'(done), int'(exp_ok));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!done && !fail && !bus_req && !prog_req, "R1", "outputs in reset",
          int'({done, fail, bus_req, prog_req}), 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!done && !fail && !bus_req && !prog_req, "R1", "outputs after reset",
          int'({done, fail, bus_req, prog_req}), 0);
  endtask

  task automatic t_uniform();
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    check_erase("uniform");
  endtask

  task automatic t_staggered();
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[3] = 2; need[10] = 4; need[15] = 3; need[12] = 2;
    check_erase("staggered");
  endtask

  task automatic t_tail();
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[15] = 3;
    check_erase("tail");
  endtask

  task automatic t_limit();
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[9] = MAXP + 1;
    check_erase("limit");
    check(pulses == MAXP, "R9", "pulses at cap", pulses, MAXP);
  endtask

  task automatic t_prefail();
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    pfail_addr = 5;
    run_flow();
    check(fail && !done, "R3", "preprogram failure flag", int'(fail), 1);
    check(prog_cnt == 6, "R3", "programming stopped", prog_cnt, 6);
    repeat (10) @(negedge clk);
    check(xfers == 0, "R3", "no erase traffic", xfers, 0);
    check(prog_cnt == 6 && !prog_req, "R3", "no further requests", prog_cnt, 6);
    pfail_addr = -1;
  endtask

  task automatic t_rerun();
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    need[7] = 2;
    check_erase("rerun after fail R11");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) need[i] = 1;
    clear_model();
    t_reset();
    t_uniform();
    t_staggered();
    t_tail();
    t_limit();
    t_prefail();
    t_rerun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule